// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block drives a small bank of pulse-width-modulated outputs. The bank has one to four channels, fixed when the block is built. Each channel has one 32-bit control word. The word packs a run bit, a duty value and a clock divider value. Software writes a whole word through a plain write strobe with a byte address, and reads it back combinationally at the same address.

A running channel slows the system clock by its divider setting plus one. It counts those slow ticks in an 8-bit period counter that wraps every 256 ticks. The output is high while the counter is below the duty value. Duty and divider changes made while a channel runs are held back until the current period ends, so a period is never cut short. Clearing the run bit forces the output low at once and resets the channel's counters.

Top module: `pwm_bank`

## Requirements
- R1: Channel k's control word sits at byte address k*16; a channel is selected only when addr[3:0] is zero and addr[ADDR_W-1:4] is below NUM_CH. Writes to any other address change no channel, and reads there return zero.
- R2: A read returns the last word written to the addressed channel with every bit outside the fields cleared: bit 31 run, bits 24:16 duty (nine bits), bits 12:0 divider. Writing 0xFFFFFFFF reads back as 0x81FF1FFF.
- R3: While a channel's run bit (bit 31) is clear, its output is low, starting in the cycle right after the write that cleared it.
- R4: A running channel with divider field D and duty d in 1..255 repeats every 256*(D+1) clocks and is high for d*(D+1) of them.
- R5: A duty of 0 keeps the output low, and a duty of 256 or more keeps it high for the whole period.
- R6: A duty or divider written while the channel runs takes effect only at the next period boundary; the period in progress finishes with the old values.
- R7: Setting the run bit restarts the channel with both counters at zero: the output is low in the cycle after the enabling write, and the first period begins one clock later.
- R8: Writing an all-zero word to a channel stops it and clears its duty and divider; the word reads back as zero and the output is low.
- R9: Channels run independently, each with its own duty and divider, and writing one channel does not disturb another.
- R10: After reset every control word reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every channel's prescaler counts it |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | ADDR_W | Byte address of the control word |
| wdata | input | 32 | Control word to write |
| rdata | output | 32 | Control word at addr, masked to its fields |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench runs one channel through a table of duty and divider pairs. It counts high cycles over a window of two full periods, which is independent of phase. The table includes the zero and full duty values, one tick high, one tick short of full, and dividers above 1; these separate the compare from the prescaler's plus-one division. Directed sequences change the duty partway through a period and sample on both sides of the boundary, stop and restart a channel to check the restart phase, and run two channels at different rates over a shared window. Writes to misaligned and unmapped addresses are followed by read-back, to show that no control word was touched.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int WORD_W   = 32;
  localparam int DUTY_W   = 8;   // period counter width; duty field is one wider
  localparam int DIV_W    = 13;
  localparam int RUN_POS  = 31;
  localparam int DUTY_POS = 16;
  localparam int DIV_POS  = 0;
  localparam int OFS_W    = 4;   // 16-byte stride per channel

  localparam logic [WORD_W-1:0] FIELD_MASK =
      (WORD_W'(1) << RUN_POS) |
      (((WORD_W'(1) << (DUTY_W + 1)) - WORD_W'(1)) << DUTY_POS) |
      (((WORD_W'(1) << DIV_W) - WORD_W'(1)) << DIV_POS);

  function automatic logic word_run(input logic [WORD_W-1:0] w);
    return w[RUN_POS];
  endfunction

  function automatic logic [DUTY_W:0] word_duty(input logic [WORD_W-1:0] w);
    return w[DUTY_POS +: DUTY_W + 1];
  endfunction

  function automatic logic [DIV_W-1:0] word_div(input logic [WORD_W-1:0] w);
    return w[DIV_POS +: DIV_W];
  endfunction
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 cfg_run  [NUM_CH],
  output logic [DUTY_W:0]      cfg_duty [NUM_CH],
  output logic [DIV_W-1:0]     cfg_div  [NUM_CH]
);
  localparam int IDX_W = ADDR_W - OFS_W;

  logic [WORD_W-1:0] ctl_q [NUM_CH];
  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic [NUM_CH-1:0] sel;     // addressed channel, one-hot or empty
  logic [NUM_CH-1:0] wr_hit;  // write event per channel

  assign idx     = addr[ADDR_W-1:OFS_W];
  assign aligned = (addr[OFS_W-1:0] == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_reg
      assign sel[gi]    = aligned && (idx == IDX_W'(gi));
      assign wr_hit[gi] = wr_en && sel[gi];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ctl_q[gi] <= '0;
        else if (wr_hit[gi])  ctl_q[gi] <= wdata & FIELD_MASK;
      end

      assign cfg_run[gi]  = word_run(ctl_q[gi]);
      assign cfg_duty[gi] = word_duty(ctl_q[gi]);
      assign cfg_div[gi]  = word_div(ctl_q[gi]);

      // R1: a write not aimed at this channel leaves its word alone
      a_r1_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit[gi] |=> $stable(ctl_q[gi]));

      // R8: an all-zero word clears the channel completely
      a_r8_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[gi] && wdata == '0) |=> (ctl_q[gi] == '0));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (sel[i]) rdata = ctl_q[i];
  end

  // R1: at most one channel answers any address
  a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_run,
  input  logic [DUTY_W:0]   cfg_duty,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              pwm_o
);
  logic              run_q;       // run bit delayed one clock
  logic              running;     // counters advance
  logic [DIV_W-1:0]  presc_q;
  logic [DUTY_W-1:0] cnt_q;
  logic [DIV_W-1:0]  act_div_q;   // settings used by the current period
  logic [DUTY_W:0]   act_duty_q;
  logic              tick;        // prescaler terminal count
  logic              period_end;  // last tick of a period

  assign running    = cfg_run && run_q;
  assign tick       = (presc_q == act_div_q);
  assign period_end = tick && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      presc_q    <= '0;
      cnt_q      <= '0;
      act_div_q  <= '0;
      act_duty_q <= '0;
    end else begin
      run_q <= cfg_run;
      if (!running) begin
        presc_q    <= '0;
        cnt_q      <= '0;
        act_div_q  <= cfg_div;
        act_duty_q <= cfg_duty;
      end else begin
        if (tick) begin
          presc_q <= '0;
          cnt_q   <= cnt_q + 1'b1;
        end else begin
          presc_q <= presc_q + 1'b1;
        end
        if (period_end) begin
          act_div_q  <= cfg_div;
          act_duty_q <= cfg_duty;
        end
      end
    end
  end

  assign pwm_o = running && ({1'b0, cnt_q} < act_duty_q);

  // R6: settings in use change only at a period boundary while running
  a_r6_hold_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !period_end) |=> ($stable(act_duty_q) && $stable(act_div_q)));

  // R4: the period counter advances only on a prescaler tick
  a_r4_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick) |=> $stable(cnt_q));

  // R7: every run starts from zeroed counters
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (cnt_q == '0 && presc_q == '0));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_CH-1:0]  pwm_out
);
  logic             cfg_run  [NUM_CH];
  logic [DUTY_W:0]  cfg_duty [NUM_CH];
  logic [DIV_W-1:0] cfg_div  [NUM_CH];

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .cfg_run  (cfg_run),
    .cfg_duty (cfg_duty),
    .cfg_div  (cfg_div)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_chan
      pwm_chan u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_run  (cfg_run[gc]),
        .cfg_duty (cfg_duty[gc]),
        .cfg_div  (cfg_div[gc]),
        .pwm_o    (pwm_out[gc])
      );
    end
  endgenerate

  // R3: a stopped channel never drives high
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_chk
      a_r3_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run[gc] |-> !pwm_out[gc]);
    end
  endgenerate
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam int NV = 8;
  localparam int VDIV  [NV] = '{0, 0, 0, 0, 0, 1, 3, 2};
  localparam int VDUTY [NV] = '{0, 1, 128, 255, 256, 64, 200, 10};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;

  pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mk(input int run, input int duty, input int dv);
    return (32'(run) << 31) | (32'(duty) << 16) | 32'(dv);
  endfunction

  // high clocks expected in one period, from R4 and R5
  function automatic int high_per_period(input int dv, input int duty);
    int d;
    d = (duty > 256) ? 256 : duty;
    return d * (dv + 1);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns at the negedge just after the write edge
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = ADDR_W'(a);
    #1;
    d = rdata;
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      h += int'(pwm_out[ch]);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    int h, h2, h3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int c = 0; c < NUM_CH; c++) begin
      rd(c * 16, r);
      check("R10 reset word", r, 0);
    end
    check("R10 reset outputs", pwm_out, 0);

    // R4 / R5: vector table on channel 0, two periods per entry
    for (int v = 0; v < NV; v++) begin
      wr(0, 32'h0);
      wr(0, mk(1, VDUTY[v], VDIV[v]));
      @(negedge clk);
      count_high(0, 2 * 256 * (VDIV[v] + 1), h);
      check((VDUTY[v] == 0 || VDUTY[v] >= 256) ? "R5 duty extreme" : "R4 duty x divider",
            h, 2 * high_per_period(VDIV[v], VDUTY[v]));
    end

    // R6: duty change partway through a period (divider 0, cnt = n-1)
    wr(0, 32'h0);
    wr(0, mk(1, 128, 0));
    repeat (9) @(negedge clk);
    addr = '0; wdata = mk(1, 32, 0); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (91) @(negedge clk);
    check("R6 old duty holds to boundary", pwm_out[0], 1);
    repeat (176) @(negedge clk);
    check("R6 new duty high part", pwm_out[0], 1);
    repeat (80) @(negedge clk);
    check("R6 new duty applies next period", pwm_out[0], 0);

    // R3 / R7: stop then restart
    wr(0, mk(0, 32, 0));
    check("R3 low right after stop", pwm_out[0], 0);
    count_high(0, 300, h);
    check("R3 stays low while stopped", h, 0);
    wr(0, mk(1, 32, 0));
    check("R7 low in cycle after enable", pwm_out[0], 0);
    @(negedge clk);
    check("R7 first tick high", pwm_out[0], 1);
    repeat (31) @(negedge clk);
    check("R7 last high tick", pwm_out[0], 1);
    @(negedge clk);
    check("R7 low after duty ticks", pwm_out[0], 0);

    // R1: address decode
    wr(16, mk(1, 5, 7));
    rd(16, r);
    check("R1 channel 1 read back", r, mk(1, 5, 7));
    rd(20, r);
    check("R1 misaligned read zero", r, 0);
    wr(20, 32'h0);
    rd(16, r);
    check("R1 misaligned write ignored", r, mk(1, 5, 7));
    wr(64, 32'hFFFF_FFFF);
    rd(64, r);
    check("R1 unmapped read zero", r, 0);
    rd(0, r);
    check("R1 unmapped write left ch0", r, mk(1, 32, 0));
    rd(32, r);
    check("R1 unmapped write left ch2", r, 0);
    check("R1 unmapped write no output ch2", pwm_out[2], 0);

    // R2 mask, R8 zero write
    wr(16, 32'hFFFF_FFFF);
    rd(16, r);
    check("R2 field mask", r, 32'h81FF_1FFF);
    @(negedge clk);
    check("R2 duty 511 drives high", pwm_out[1], 1);
    wr(16, 32'h0);
    rd(16, r);
    check("R8 zero word reads zero", r, 0);
    check("R8 zero word output low", pwm_out[1], 0);

    // R9: independent channels
    wr(0, 32'h0);
    wr(32, mk(1, 64, 0));
    wr(48, mk(1, 100, 1));
    @(negedge clk);
    h2 = 0; h3 = 0; h = 0;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      h2 += int'(pwm_out[2]);
      h3 += int'(pwm_out[3]);
      h  += int'(pwm_out[0]) + int'(pwm_out[1]);
    end
    check("R9 channel 2 high count", h2, 2 * high_per_period(0, 64));
    check("R9 channel 3 high count", h3, high_per_period(1, 100));
    check("R9 idle channels low", h, 0);
    rd(32, r);
    check("R9 channel 2 word intact", r, mk(1, 64, 0));

    summary();
    $finish;
  end
endmodule